// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message table and the pending-bit array for a set of message-signalled interrupt vectors, along with the two function-level control bits (enable and function mask). Software reaches the table, the pending array and the control word through a single register access port. Hardware sources raise interrupts on a per-vector trigger port. The block turns each trigger into a message that carries the vector's 64-bit address and 32-bit data, and sends it out on a valid/ready port.

A trigger is recorded as a pending bit when its vector is masked, either by the vector's own mask or by the function mask. Such a trigger is never lost. The pending message is sent later:
- Clearing a vector's mask replays that one vector.
- Releasing the function mask starts a walker that visits every entry in ascending order and sends each unmasked, pending entry.

A three-state machine shares the single output port between these sources:
- `ST_IDLE` arbitrates, in the order scan, then replay, then new trigger.
- `ST_SCAN` examines one entry per cycle.
- `ST_SEND` holds a message until the receiver accepts it.

The transitions are:
- `ST_IDLE` to `ST_SCAN` when a scan request is waiting.
- `ST_IDLE` to `ST_SEND` on a replay or on an unmasked trigger.
- `ST_SCAN` to `ST_SEND` when the current entry is due.
- `ST_SCAN` to `ST_IDLE` after the last entry, or when the function is masked or disabled.
- `ST_SEND` back to `ST_SCAN`, or to `ST_IDLE`, on the handshake.

Top module: `msix_vector_ctrl`

## Requirements
- R1: After reset, every table word, pending bit, the enable bit and the function mask read as zero, `msg_valid` is low, and `trig_ready` is high.
- R2: Access space is chosen by `acc_space` (0 table, 1 pending array, 2 control word). Size code 2 is a 4-byte access and size code 3 is an 8-byte access. In the table, entry = offset/16, and the 4-byte word at entry offset 0, 4, 8 and 12 is address low, address high, message data and vector control. Read data appears on `rd_data` with `rd_valid` one cycle after the request.
- R3: An 8-byte table access at entry offset 0 carries address low in bits 31:0 and address high in bits 63:32. An 8-byte access at entry offset 8 carries message data in bits 31:0 and vector control in bits 63:32.
- R4: A write with an unsupported size code, a misaligned offset or an out-of-range index changes nothing. A read of the same kind returns zero.
- R5: Only bit 0 of vector control (the vector mask) is stored. The other bits of that word read as zero.
- R6: The pending array puts vector v at quadword v/64 (byte offset 8*(v/64)), bit v mod 64. It is readable as a whole quadword or as either 32-bit half (offset +0 low, +4 high). Writes to it leave it unchanged.
- R7: The control word is a 4-byte access at offset 0. Bit 15 is enable and bit 14 is function mask, and only these two bits are writable. Bits 10:0 read as the vector count minus one, and all other bits read as zero.
- R8: With enable set, an accepted trigger on an unmasked vector while the function mask is clear raises `msg_valid` in the next cycle, carrying that vector's address and data. The message is held stable until `msg_ready`.
- R9: With enable set, a trigger on a vector whose mask bit is set, or while the function mask is set, sets that vector's pending bit and sends nothing.
- R10: A table write that clears a vector's mask while the function mask is clear and its pending bit is set sends that vector's message and clears its pending bit.
- R11: When the function mask goes from 1 to 0 with enable set, every entry is visited in ascending index order. Each unmasked pending entry has its message sent and its pending bit cleared. Masked entries keep their pending bits.
- R12: With enable clear, triggers are accepted and dropped: no message is sent and no pending bit is set.
- R13: While a message is waiting for the receiver, a scan is running or due, or a replay is due, `trig_ready` is low and a held trigger waits. Scan work is served before a waiting trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | 0 table, 1 pending array, 2 control word |
| acc_offset | input | $clog2(NVEC)+4 | Byte offset within the space |
| acc_size | input | 2 | 2 = 4 bytes, 3 = 8 bytes, others unsupported |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| trig_valid | input | 1 | Interrupt trigger request |
| trig_vec | input | $clog2(NVEC) | Triggered vector index |
| trig_ready | output | 1 | Trigger accepted this cycle |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Read data is due exactly one cycle after the request, so each read is sampled on the falling edge right after the capturing edge. A direct trigger's message must already be visible on the first falling edge after the edge that accepted it, and is checked there with no waiting. A replay arrives two edges after the unmasking write, and scan messages arrive after a walk whose length depends on the entry index. These are collected with a bounded cycle limit and compared in the order they arrive. Cases that must send nothing watch `msg_valid` for several cycles and then read the pending array.

// File: rtl/msix_ctl_pkg.sv
package msix_ctl_pkg;
    typedef enum logic [1:0] {
        SP_TABLE = 2'd0,
        SP_PEND  = 2'd1,
        SP_CTRL  = 2'd2,
        SP_NONE  = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_SEND = 2'd2
    } sched_state_e;

    localparam logic [1:0] SZ_DWORD = 2'd2;
    localparam logic [1:0] SZ_QWORD = 2'd3;
    localparam int         MAX_VECTORS = 2048;
endpackage

// File: rtl/msix_vtab.sv
module msix_vtab
    import msix_ctl_pkg::*;
#(
    parameter int NVEC = 16,
    localparam int IW   = $clog2(NVEC),
    localparam int OFFW = IW + 4,
    localparam int NQ   = (NVEC + 63) / 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [1:0]      acc_space,
    input  logic [OFFW-1:0] acc_offset,
    input  logic [1:0]      acc_size,
    input  logic [63:0]     acc_wdata,
    output logic            rd_valid,
    output logic [63:0]     rd_data,
    input  logic [NVEC-1:0] pend_set_i,
    input  logic [NVEC-1:0] pend_clr_i,
    input  logic [IW-1:0]   sel_idx_i,
    output logic [63:0]     sel_addr_o,
    output logic [31:0]     sel_data_o,
    output logic [NVEC-1:0] mask_o,
    output logic [NVEC-1:0] pend_o,
    output logic [NVEC-1:0] unmask_o,
    output logic            enable_o,
    output logic            fmask_o,
    output logic            scan_start_o
);
    logic [63:0]     addr_q [NVEC];
    logic [31:0]     data_q [NVEC];
    logic [NVEC-1:0] mask_q, pend_q;
    logic            enable_q, fmask_q;
    logic [63:0]     rd_q;
    logic            rdv_q;

    space_e           space;
    logic [IW-1:0]    tidx;
    logic [IW:0]      qidx;
    logic             sz_dw, sz_qw, aligned;
    logic             tbl_hit, pnd_hit, ctl_hit;
    logic             mask_wr, mask_new;
    logic [NQ*64-1:0] pend_pad;
    logic [63:0]      pword, rd_next;

    always_comb begin
        space   = space_e'(acc_space);
        tidx    = acc_offset[OFFW-1:4];
        qidx    = acc_offset[OFFW-1:3];
        sz_dw   = (acc_size == SZ_DWORD);
        sz_qw   = (acc_size == SZ_QWORD);
        aligned = (sz_dw && acc_offset[1:0] == 2'b00) || (sz_qw && acc_offset[2:0] == 3'b000);
        tbl_hit = acc_valid && space == SP_TABLE && aligned && int'(tidx) < NVEC;
        pnd_hit = acc_valid && space == SP_PEND && aligned && int'(qidx) < NQ;
        ctl_hit = acc_valid && space == SP_CTRL && sz_dw && acc_offset == '0;
        mask_wr  = tbl_hit && acc_write &&
                   ((sz_qw && acc_offset[3]) || (sz_dw && acc_offset[3:2] == 2'd3));
        mask_new = sz_qw ? acc_wdata[32] : acc_wdata[0];
        unmask_o = '0;
        if (mask_wr && mask_q[tidx] && !mask_new) unmask_o[tidx] = 1'b1;
        scan_start_o = ctl_hit && acc_write && fmask_q && !acc_wdata[14] && acc_wdata[15];
    end

    // read mux: table, pending quadword or halves, control word
    always_comb begin
        pend_pad = '0;
        pend_pad[NVEC-1:0] = pend_q;
        pword   = '0;
        rd_next = '0;
        if (tbl_hit) begin
            if (sz_qw) begin
                rd_next = acc_offset[3] ? {31'b0, mask_q[tidx], data_q[tidx]} : addr_q[tidx];
            end else begin
                unique case (acc_offset[3:2])
                    2'd0: rd_next = {32'b0, addr_q[tidx][31:0]};
                    2'd1: rd_next = {32'b0, addr_q[tidx][63:32]};
                    2'd2: rd_next = {32'b0, data_q[tidx]};
                    default: rd_next = {63'b0, mask_q[tidx]};
                endcase
            end
        end else if (pnd_hit) begin
            pword = pend_pad[int'(qidx)*64 +: 64];
            if (sz_qw) rd_next = pword;
            else       rd_next = acc_offset[2] ? {32'b0, pword[63:32]} : {32'b0, pword[31:0]};
        end else if (ctl_hit) begin
            rd_next = {48'b0, enable_q, fmask_q, 3'b000, 11'(NVEC - 1)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NVEC; v++) begin
                addr_q[v] <= '0;
                data_q[v] <= '0;
            end
            mask_q   <= '0;
            pend_q   <= '0;
            enable_q <= 1'b0;
            fmask_q  <= 1'b0;
            rd_q     <= '0;
            rdv_q    <= 1'b0;
        end else begin
            if (tbl_hit && acc_write) begin
                if (sz_qw) begin
                    if (!acc_offset[3]) addr_q[tidx] <= acc_wdata;
                    else                data_q[tidx] <= acc_wdata[31:0];
                end else begin
                    unique case (acc_offset[3:2])
                        2'd0: addr_q[tidx][31:0]  <= acc_wdata[31:0];
                        2'd1: addr_q[tidx][63:32] <= acc_wdata[31:0];
                        2'd2: data_q[tidx]        <= acc_wdata[31:0];
                        default: ;
                    endcase
                end
            end
            if (mask_wr) mask_q[tidx] <= mask_new;
            pend_q <= (pend_q | pend_set_i) & ~pend_clr_i;
            if (ctl_hit && acc_write) begin
                enable_q <= acc_wdata[15];
                fmask_q  <= acc_wdata[14];
            end
            rdv_q <= acc_valid && !acc_write;
            rd_q  <= rd_next;
        end
    end

    assign sel_addr_o = (int'(sel_idx_i) < NVEC) ? addr_q[sel_idx_i] : '0;
    assign sel_data_o = (int'(sel_idx_i) < NVEC) ? data_q[sel_idx_i] : '0;
    assign mask_o     = mask_q;
    assign pend_o     = pend_q;
    assign enable_o   = enable_q;
    assign fmask_o    = fmask_q;
    assign rd_valid   = rdv_q;
    assign rd_data    = rd_q;

    assert_masked_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_set_i & ~mask_q)) |-> fmask_q);
    assert_no_clear_fmask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fmask_q |-> (pend_clr_i == '0));
endmodule

// File: rtl/msix_sched.sv
module msix_sched
    import msix_ctl_pkg::*;
#(
    parameter int NVEC = 16,
    localparam int IW = $clog2(NVEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] mask,
    input  logic [NVEC-1:0] pend,
    input  logic [NVEC-1:0] unmask,
    input  logic            enable,
    input  logic            fmask,
    input  logic            scan_start,
    input  logic            trig_valid,
    input  logic [IW-1:0]   trig_vec,
    output logic            trig_ready,
    input  logic [63:0]     sel_addr,
    input  logic [31:0]     sel_data,
    output logic [IW-1:0]   sel_idx,
    output logic [NVEC-1:0] pend_set,
    output logic [NVEC-1:0] pend_clr,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [63:0]     msg_addr,
    output logic [31:0]     msg_data
);
    localparam logic [IW-1:0] LAST = IW'(NVEC - 1);

    sched_state_e    state_q, state_d;
    logic [IW-1:0]   scan_idx_q, replay_idx;
    logic [NVEC-1:0] replay_q, replay_live, replay_clr;
    logic            scan_req_q, from_scan_q, from_scan_d;
    logic            replay_any, load, scan_rst, scan_adv, scan_take, idle_off;
    logic [63:0]     maddr_q;
    logic [31:0]     mdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        replay_live = replay_q & pend & ~mask & {NVEC{!fmask}};
        replay_any  = 1'b0;
        replay_idx  = '0;
        for (int v = NVEC - 1; v >= 0; v--) begin
            if (replay_live[v]) begin
                replay_any = 1'b1;
                replay_idx = IW'(v);
            end
        end
        trig_ready  = !enable || (state_q == ST_IDLE && !scan_req_q && !replay_any);
        state_d     = state_q;
        sel_idx     = scan_idx_q;
        load        = 1'b0;
        pend_set    = '0;
        pend_clr    = '0;
        replay_clr  = '0;
        scan_rst    = 1'b0;
        scan_adv    = 1'b0;
        scan_take   = 1'b0;
        idle_off    = 1'b0;
        from_scan_d = from_scan_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!enable) begin
                    idle_off = 1'b1;
                end else if (scan_req_q) begin
                    scan_take = 1'b1;
                    scan_rst  = 1'b1;
                    state_d   = ST_SCAN;
                end else if (replay_any) begin
                    sel_idx                = replay_idx;
                    load                   = 1'b1;
                    pend_clr[replay_idx]   = 1'b1;
                    replay_clr[replay_idx] = 1'b1;
                    from_scan_d            = 1'b0;
                    state_d                = ST_SEND;
                end else if (trig_valid && int'(trig_vec) < NVEC) begin
                    sel_idx = trig_vec;
                    if (fmask || mask[trig_vec]) begin
                        pend_set[trig_vec] = 1'b1;
                    end else begin
                        load        = 1'b1;
                        from_scan_d = 1'b0;
                        state_d     = ST_SEND;
                    end
                end
            end
            ST_SCAN: begin
                if (!enable || fmask) begin
                    state_d = ST_IDLE;
                end else if (pend[scan_idx_q] && !mask[scan_idx_q]) begin
                    load                 = 1'b1;
                    pend_clr[scan_idx_q] = 1'b1;
                    from_scan_d          = 1'b1;
                    state_d              = ST_SEND;
                end else if (scan_idx_q == LAST) begin
                    state_d = ST_IDLE;
                end else begin
                    scan_adv = 1'b1;
                end
            end
            ST_SEND: begin
                if (msg_ready) begin
                    if (!from_scan_q || scan_idx_q == LAST) begin
                        state_d = ST_IDLE;
                    end else begin
                        scan_adv = 1'b1;
                        state_d  = ST_SCAN;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_idx_q  <= '0;
            scan_req_q  <= 1'b0;
            from_scan_q <= 1'b0;
            replay_q    <= '0;
            maddr_q     <= '0;
            mdata_q     <= '0;
        end else begin
            scan_req_q  <= (scan_req_q && !scan_take && !idle_off) || scan_start;
            from_scan_q <= from_scan_d;
            replay_q    <= ((scan_take || idle_off) ? '0 : (replay_q & ~replay_clr))
                           | (unmask & pend & {NVEC{enable && !fmask}});
            if (scan_rst)      scan_idx_q <= '0;
            else if (scan_adv) scan_idx_q <= scan_idx_q + 1'b1;
            if (load) begin
                maddr_q <= sel_addr;
                mdata_q <= sel_data;
            end
        end
    end

    assign msg_valid = (state_q == ST_SEND);
    assign msg_addr  = maddr_q;
    assign msg_data  = mdata_q;

    assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    assert_send_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(enable));
    assert_single_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr));
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl
    import msix_ctl_pkg::*;
#(
    parameter int NVEC = 16,
    localparam int IW   = $clog2(NVEC),
    localparam int OFFW = IW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [1:0]      acc_space,
    input  logic [OFFW-1:0] acc_offset,
    input  logic [1:0]      acc_size,
    input  logic [63:0]     acc_wdata,
    output logic            rd_valid,
    output logic [63:0]     rd_data,
    input  logic            trig_valid,
    input  logic [IW-1:0]   trig_vec,
    output logic            trig_ready,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [63:0]     msg_addr,
    output logic [31:0]     msg_data
);
    logic [NVEC-1:0] mask_w, pend_w, unmask_w, pset_w, pclr_w;
    logic            enable_w, fmask_w, scan_start_w;
    logic [IW-1:0]   sel_idx_w;
    logic [63:0]     sel_addr_w;
    logic [31:0]     sel_data_w;

    msix_vtab #(.NVEC(NVEC)) u_vtab (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_space    (acc_space),
        .acc_offset   (acc_offset),
        .acc_size     (acc_size),
        .acc_wdata    (acc_wdata),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .pend_set_i   (pset_w),
        .pend_clr_i   (pclr_w),
        .sel_idx_i    (sel_idx_w),
        .sel_addr_o   (sel_addr_w),
        .sel_data_o   (sel_data_w),
        .mask_o       (mask_w),
        .pend_o       (pend_w),
        .unmask_o     (unmask_w),
        .enable_o     (enable_w),
        .fmask_o      (fmask_w),
        .scan_start_o (scan_start_w)
    );

    msix_sched #(.NVEC(NVEC)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask       (mask_w),
        .pend       (pend_w),
        .unmask     (unmask_w),
        .enable     (enable_w),
        .fmask      (fmask_w),
        .scan_start (scan_start_w),
        .trig_valid (trig_valid),
        .trig_vec   (trig_vec),
        .trig_ready (trig_ready),
        .sel_addr   (sel_addr_w),
        .sel_data   (sel_data_w),
        .sel_idx    (sel_idx_w),
        .pend_set   (pset_w),
        .pend_clr   (pclr_w),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_addr   (msg_addr),
        .msg_data   (msg_data)
    );
endmodule

// File: tb/msix_vector_ctrl_test.sv
module msix_vector_ctrl_test;
    localparam int NV   = 70;
    localparam int IW   = $clog2(NV);
    localparam int OFFW = IW + 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]      acc_space = 2'd0, acc_size = 2'd2;
    logic [OFFW-1:0] acc_offset = '0;
    logic [63:0]     acc_wdata = '0;
    logic            rd_valid;
    logic [63:0]     rd_data;
    logic            trig_valid = 1'b0;
    logic [IW-1:0]   trig_vec = '0;
    logic            trig_ready, msg_valid;
    logic            msg_ready = 1'b1;
    logic [63:0]     msg_addr;
    logic [31:0]     msg_data;

    int checks = 0;
    int errors = 0;

    msix_vector_ctrl #(.NVEC(NV)) uut (.*);

    always #5 clk = ~clk;

    // programming table: vector, address, data
    localparam int NPROG = 4;
    localparam int          PV [NPROG] = '{0, 3, 5, 65};
    localparam logic [63:0] PA [NPROG] = '{64'h0000_0001_FEE0_0000, 64'h0000_0002_FEE0_3000,
                                           64'h0000_0003_FEE0_5000, 64'h0000_0004_FEE4_1000};
    localparam logic [31:0] PD [NPROG] = '{32'h0000_4000, 32'h0000_4103,
                                           32'h0000_4205, 32'h0000_4341};

    localparam logic [1:0] TB = 2'd0, PN = 2'd1, CT = 2'd2;
    localparam logic [1:0] DW = 2'd2, QW = 2'd3;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [OFFW-1:0] toff(int v, int byteoff);
        return OFFW'(v * 16 + byteoff);
    endfunction

    task automatic wr(logic [1:0] sp, logic [OFFW-1:0] off, logic [1:0] sz, logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_space = sp;
        acc_offset = off; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(logic [1:0] sp, logic [OFFW-1:0] off, logic [1:0] sz, output logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_space = sp;
        acc_offset = off; acc_size = sz;
        @(negedge clk);
        acc_valid = 1'b0;
        d = rd_valid ? rd_data : 64'hDEAD_DEAD_DEAD_DEAD;
    endtask

    task automatic rd_chk(string tag, logic [1:0] sp, logic [OFFW-1:0] off, logic [1:0] sz,
                          logic [63:0] exp);
        logic [63:0] d;
        rd(sp, off, sz, d);
        check(tag, d, exp);
    endtask

    // returns on the falling edge after the accepting clock edge
    task automatic send_trig(int v);
        @(negedge clk);
        trig_valid = 1'b1;
        trig_vec = IW'(v);
        while (!trig_ready) @(negedge clk);
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic wait_msg(string tag, int k, int limit);
        int n = 0;
        while (!msg_valid && n < limit) begin
            @(negedge clk);
            n++;
        end
        check({tag, " valid"}, 64'(msg_valid), 64'd1);
        check({tag, " addr"}, msg_addr, PA[k]);
        check({tag, " data"}, 64'(msg_data), 64'(PD[k]));
        @(negedge clk);
    endtask

    task automatic quiet(string tag, int n);
        logic seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(tag, 64'(seen), 64'd0);
    endtask

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 msg_valid", 64'(msg_valid), 64'd0);
        check("R1 trig_ready", 64'(trig_ready), 64'd1);
        rd_chk("R1 table word", TB, toff(3, 0), DW, 64'd0);
        rd_chk("R1 pending", PN, '0, QW, 64'd0);
        rd_chk("R1/R7 control", CT, '0, DW, 64'h0045);

        // R2 R3: program the table with 4-byte writes, read back 8-byte
        for (int k = 0; k < NPROG; k++) begin
            wr(TB, toff(PV[k], 0), DW, {32'hAAAA_AAAA, PA[k][31:0]});
            wr(TB, toff(PV[k], 4), DW, {32'h5555_5555, PA[k][63:32]});
            wr(TB, toff(PV[k], 8), DW, {32'h0, PD[k]});
            rd_chk("R3 qword addr", TB, toff(PV[k], 0), QW, PA[k]);
            rd_chk("R3 qword data/ctl", TB, toff(PV[k], 8), QW, {32'h0, PD[k]});
            rd_chk("R2 dword addr hi", TB, toff(PV[k], 4), DW, {32'h0, PA[k][63:32]});
        end

        // R5: 8-byte write sets vector 5 mask with junk upper bits
        wr(TB, toff(5, 8), QW, {32'hFFFF_FFFF, PD[2]});
        rd_chk("R5 vector control", TB, toff(5, 12), DW, 64'd1);
        rd_chk("R3 qword mask", TB, toff(5, 8), QW, {32'h1, PD[2]});

        // R4 bad accesses
        wr(TB, toff(0, 2), DW, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(TB, toff(0, 4), QW, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(TB, toff(0, 8), 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R4 addr untouched", TB, toff(0, 0), QW, PA[0]);
        rd_chk("R4 data untouched", TB, toff(0, 8), QW, {32'h0, PD[0]});
        rd_chk("R4 misaligned read", TB, toff(0, 2), DW, 64'd0);
        rd_chk("R4 bad size read", TB, toff(0, 0), 2'd1, 64'd0);
        rd_chk("R4 range read", TB, toff(NV, 0), DW, 64'd0);

        // R7 control word
        wr(CT, '0, DW, 64'hFFFF);
        rd_chk("R7 control all", CT, '0, DW, 64'hC045);
        wr(CT, '0, DW, 64'h8000);
        rd_chk("R7 control enable", CT, '0, DW, 64'h8045);

        // R8 + R13: direct send with receiver stall
        msg_ready = 1'b0;
        send_trig(3);
        check("R8 valid next cycle", 64'(msg_valid), 64'd1);
        check("R8 addr", msg_addr, PA[1]);
        repeat (3) @(negedge clk);
        check("R8 held", 64'(msg_valid), 64'd1);
        check("R8 held addr", msg_addr, PA[1]);
        check("R13 blocked", 64'(trig_ready), 64'd0);
        msg_ready = 1'b1;
        wait_msg("R8 accept", 1, 2);

        // R9 masked vector
        send_trig(5);
        quiet("R9 no message", 4);
        rd_chk("R9 pending lo", PN, '0, DW, 64'h20);

        // R10 unmask replays
        wr(TB, toff(5, 12), DW, 64'd0);
        wait_msg("R10 replay", 2, 4);
        rd_chk("R10 pending cleared", PN, '0, QW, 64'd0);

        // R11 function-mask release scan
        wr(CT, '0, DW, 64'hC000);
        wr(TB, toff(3, 12), DW, 64'd1);
        send_trig(65);
        send_trig(0);
        send_trig(3);
        quiet("R9 fmask no message", 3);
        rd_chk("R6 pending q0", PN, 11'd0, QW, 64'h9);
        rd_chk("R6 pending q1 lo", PN, 11'd8, DW, 64'h2);
        rd_chk("R6 pending q1 hi", PN, 11'd12, DW, 64'h0);
        wr(TB, toff(5, 12), DW, 64'd1);
        wr(TB, toff(5, 12), DW, 64'd0);
        quiet("R10 no replay under fmask", 3);
        wr(CT, '0, DW, 64'h8000);
        wait_msg("R11 scan first", 0, 20);
        wait_msg("R11 scan second", 3, 200);
        rd_chk("R11 masked stays", PN, 11'd0, QW, 64'h8);
        rd_chk("R11 q1 cleared", PN, 11'd8, QW, 64'h0);

        // R6 read-only pending
        wr(PN, 11'd0, QW, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R6 write ignored", PN, 11'd0, QW, 64'h8);
        wr(PN, 11'd0, DW, 64'h0);
        rd_chk("R6 clear ignored", PN, 11'd0, DW, 64'h8);

        // R10 replay of vector 3
        wr(TB, toff(3, 12), DW, 64'd0);
        wait_msg("R10 replay v3", 1, 4);

        // R13 scan before waiting trigger
        wr(CT, '0, DW, 64'hC000);
        send_trig(3);
        msg_ready = 1'b0;
        wr(CT, '0, DW, 64'h8000);
        check("R13 ready low on scan", 64'(trig_ready), 64'd0);
        fork
            send_trig(65);
        join_none
        repeat (6) @(negedge clk);
        check("R13 stalled under hold", 64'(trig_ready), 64'd0);
        msg_ready = 1'b1;
        wait_msg("R13 scan first", 1, 10);
        wait_msg("R13 trigger after", 3, 200);
        wait fork;

        // R12 disabled
        wr(CT, '0, DW, 64'h0000);
        check("R12 ready", 64'(trig_ready), 64'd1);
        send_trig(0);
        wr(TB, toff(3, 12), DW, 64'd1);
        send_trig(3);
        quiet("R12 no message", 4);
        rd_chk("R12 no pending", PN, 11'd0, QW, 64'h0);

        summary();
        $finish;
    end
endmodule